// File: doc/BRIEF.md
# Oscillator Range Monitor with Failover

This block watches a main oscillator by counting its rising edges over a fixed window of reference-clock cycles and raises a sticky failure flag when the count falls below or rises above a pair of programmable limits. The reference clock is the high-frequency low-power oscillator. While the flag is set, every clock domain that currently takes its clock from the main oscillator is told to move to the low-power oscillator through a per-domain override output.

The counting runs in the main oscillator domain. Each result crosses into the reference domain through a request/acknowledge handshake, so the compare never sees a changing value. If the main oscillator stops and no acknowledge returns before the next window closes, that counts as a failure. A reference-valid input reports whether the reference oscillator is enabled. While monitoring is active and the reference is reported invalid, a failure is raised: switching off the reference without first taking control of the monitor leads to a failover onto a dead clock. Bits 24 and 25 of a test-control word decide whether monitoring follows the hardware default (always on) or a software enable.

The first measurement after monitoring starts, and the first one after a stall, is discarded because it covers a partial window.

Top module: `oscmon_top`

## Requirements
- R1: With `ctl_reg_i[24]` = 0, monitoring is on whatever `ctl_reg_i[25]` holds. With `ctl_reg_i[24]` = 1, monitoring is on exactly when `ctl_reg_i[25]` = 1.
- R2: While monitoring is on, a count of main-oscillator cycles per window of `WIN_CYCLES` reference cycles below `lim_lo_i` sets `fail_o`.
- R3: While monitoring is on, a count above `lim_hi_i` sets `fail_o`.
- R4: While monitoring is on and `ref_valid_i` = 1, a count within [`lim_lo_i`, `lim_hi_i`] raises no failure.
- R5: While monitoring is on, a stopped main oscillator sets `fail_o` at the end of the window after its last result.
- R6: While monitoring is on, `ref_valid_i` = 0 sets `fail_o` at the next reference clock edge.
- R7: While monitoring is off, no new failure is raised, `ref_valid_i` and the oscillator state are ignored, and the edge counter is held in reset.
- R8: `fail_o` stays set until `fail_clr_i` is sampled high in a cycle with no new failure. A new failure in the same cycle as the clear wins.
- R9: `dom_force_lpo_o[i]` equals `fail_o` AND `dom_uses_osc_i[i]` for every domain i.
- R10: After reset, `fail_o` = 0 and every `dom_force_lpo_o` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference clock (low-power oscillator) |
| rst_i | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk_i | input | 1 | Main oscillator clock under test |
| ctl_reg_i | input | 32 | Test-control word; bit 24 selects software control, bit 25 is the software enable |
| ref_valid_i | input | 1 | High while the reference oscillator is enabled |
| lim_lo_i | input | CNT_W | Lowest acceptable count per window |
| lim_hi_i | input | CNT_W | Highest acceptable count per window |
| fail_clr_i | input | 1 | Clears the sticky failure flag |
| dom_uses_osc_i | input | N_DOM | Per-domain flag: domain is sourced from the main oscillator |
| fail_o | output | 1 | Sticky oscillator failure flag |
| dom_force_lpo_o | output | N_DOM | Per-domain override to the low-power oscillator |

## Verification
A reference-valid failure lands one reference edge after the input drops, so the bench samples two cycles later. A count result needs up to one window to gather, plus two synchronizer stages each way, and the first result after any change is discarded. For that reason the bench waits three windows after changing the oscillator or the control word, pulses the clear, and then waits two more windows plus a margin before it samples `fail_o` and the override bus. All sampling happens on the falling reference edge. Random oscillator periods whose expected count lies within two of a limit are redrawn, so the one-count uncertainty of edge counting cannot flip a verdict.

// File: rtl/oscmon_pkg.sv
`timescale 1ns/1ps
package oscmon_pkg;

    localparam int unsigned CTL_SW_SEL_BIT = 24;
    localparam int unsigned CTL_SW_EN_BIT  = 25;

    typedef enum logic [2:0] {
        EVT_NONE,
        EVT_SLOW,
        EVT_FAST,
        EVT_STALL,
        EVT_NOREF
    } fail_evt_e;

    typedef struct packed {
        logic req;
        logic pending;
        logic primed;
    } hs_state_t;

    function automatic logic mon_enable(input logic [31:0] ctl);
        return ctl[CTL_SW_SEL_BIT] ? ctl[CTL_SW_EN_BIT] : 1'b1;
    endfunction

endpackage

// File: rtl/oscmon_sync.sv
`timescale 1ns/1ps
module oscmon_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/oscmon_osc_cnt.sv
`timescale 1ns/1ps
module oscmon_osc_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             osc_clk_i,
    input  logic             hold_rst_i,
    input  logic             req_i,
    output logic             ack_o,
    output logic [CNT_W-1:0] count_o
);
    logic osc_rst;
    logic req_s;
    logic seen_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_q;

    oscmon_sync #(.W(1), .STAGES(2)) u_rst_sync (
        .clk(osc_clk_i), .rst(1'b0), .d(hold_rst_i), .q(osc_rst)
    );

    oscmon_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk(osc_clk_i), .rst(osc_rst), .d(req_i), .q(req_s)
    );

    always_ff @(posedge osc_clk_i) begin
        if (osc_rst) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (req_s != seen_q) begin
            hold_q <= cnt_q;
            cnt_q  <= CNT_W'(1);
            seen_q <= req_s;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign ack_o   = seen_q;
    assign count_o = hold_q;
endmodule

// File: rtl/oscmon_ref_ctl.sv
`timescale 1ns/1ps
module oscmon_ref_ctl
    import oscmon_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int WIN_CYCLES = 1024
) (
    input  logic             ref_clk_i,
    input  logic             rst_i,
    input  logic             mon_en_i,
    input  logic             ref_valid_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    input  logic             fail_clr_i,
    input  logic             ack_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             req_o,
    output logic             fail_o
);
    localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

    logic             blk_rst;
    logic             ack_s;
    logic [WIN_W-1:0] win_q;
    logic             win_end;
    logic             ack_done;
    hs_state_t        hs_q, hs_d;
    fail_evt_e        evt;
    logic             fail_q;

    assign blk_rst = rst_i | ~mon_en_i;

    oscmon_sync #(.W(1), .STAGES(2)) u_ack_sync (
        .clk(ref_clk_i), .rst(blk_rst), .d(ack_i), .q(ack_s)
    );

    always_ff @(posedge ref_clk_i) begin
        if (blk_rst)      win_q <= '0;
        else if (win_end) win_q <= '0;
        else              win_q <= win_q + WIN_W'(1);
    end

    assign win_end  = (win_q == WIN_LAST);
    assign ack_done = hs_q.pending && (ack_s == hs_q.req);

    always_comb begin
        hs_d = hs_q;
        if (ack_done) begin
            hs_d.pending = 1'b0;
            hs_d.primed  = 1'b1;
        end
        if (win_end && hs_q.pending && !ack_done) begin
            hs_d.primed = 1'b0;
        end
        if (win_end && (!hs_q.pending || ack_done)) begin
            hs_d.req     = ~hs_q.req;
            hs_d.pending = 1'b1;
        end
    end

    always_ff @(posedge ref_clk_i) begin
        if (blk_rst) hs_q <= '0;
        else         hs_q <= hs_d;
    end

    always_comb begin
        evt = EVT_NONE;
        if (mon_en_i) begin
            if (!ref_valid_i) begin
                evt = EVT_NOREF;
            end else if (ack_done && hs_q.primed) begin
                if (count_i < lim_lo_i)      evt = EVT_SLOW;
                else if (count_i > lim_hi_i) evt = EVT_FAST;
            end else if (win_end && hs_q.pending && !ack_done) begin
                evt = EVT_STALL;
            end
        end
    end

    always_ff @(posedge ref_clk_i) begin
        if (rst_i)                fail_q <= 1'b0;
        else if (evt != EVT_NONE) fail_q <= 1'b1;
        else if (fail_clr_i)      fail_q <= 1'b0;
    end

    assign req_o  = hs_q.req;
    assign fail_o = fail_q;
endmodule

// File: rtl/oscmon_top.sv
`timescale 1ns/1ps
module oscmon_top
    import oscmon_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int WIN_CYCLES = 1024,
    parameter int N_DOM      = 4
) (
    input  logic             ref_clk_i,
    input  logic             rst_i,
    input  logic             osc_clk_i,
    input  logic [31:0]      ctl_reg_i,
    input  logic             ref_valid_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    input  logic             fail_clr_i,
    input  logic [N_DOM-1:0] dom_uses_osc_i,
    output logic             fail_o,
    output logic [N_DOM-1:0] dom_force_lpo_o
);
    logic             mon_en;
    logic             osc_hold_q;
    logic             req;
    logic             ack;
    logic [CNT_W-1:0] count;
    logic             fail;
    logic             unused_ctl;

    assign mon_en     = mon_enable(ctl_reg_i);
    assign unused_ctl = ^{ctl_reg_i[31:26], ctl_reg_i[23:0]};

    always_ff @(posedge ref_clk_i) begin
        osc_hold_q <= rst_i | ~mon_en;
    end

    oscmon_osc_cnt #(.CNT_W(CNT_W)) u_osc_cnt (
        .osc_clk_i  (osc_clk_i),
        .hold_rst_i (osc_hold_q),
        .req_i      (req),
        .ack_o      (ack),
        .count_o    (count)
    );

    oscmon_ref_ctl #(.CNT_W(CNT_W), .WIN_CYCLES(WIN_CYCLES)) u_ref_ctl (
        .ref_clk_i   (ref_clk_i),
        .rst_i       (rst_i),
        .mon_en_i    (mon_en),
        .ref_valid_i (ref_valid_i),
        .lim_lo_i    (lim_lo_i),
        .lim_hi_i    (lim_hi_i),
        .fail_clr_i  (fail_clr_i),
        .ack_i       (ack),
        .count_i     (count),
        .req_o       (req),
        .fail_o      (fail)
    );

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        assign dom_force_lpo_o[g] = fail & dom_uses_osc_i[g];
    end

    assign fail_o = fail;
endmodule

// File: rtl/oscmon_chk.sv
`timescale 1ns/1ps
module oscmon_chk
    import oscmon_pkg::*;
#(
    parameter int N_DOM = 4
) (
    input logic             ref_clk_i,
    input logic             rst_i,
    input logic [31:0]      ctl_reg_i,
    input logic             ref_valid_i,
    input logic             fail_clr_i,
    input logic [N_DOM-1:0] dom_uses_osc_i,
    input logic             fail_o,
    input logic [N_DOM-1:0] dom_force_lpo_o
);
    logic en_c;
    assign en_c = mon_enable(ctl_reg_i);

    // R8
    fail_sticky_chk: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        (fail_o && !fail_clr_i) |=> fail_o);

    // R8
    fail_drop_needs_clear_chk: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        $fell(fail_o) |-> $past(fail_clr_i));

    // R6
    noref_raises_fail_chk: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        (en_c && !ref_valid_i) |=> fail_o);

    // R7
    off_no_new_fail_chk: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        (!en_c && !fail_o) |=> !fail_o);

    // R9
    failover_map_chk: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        fail_o |-> (dom_force_lpo_o == dom_uses_osc_i));

    // R9
    no_force_when_ok_chk: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        !fail_o |-> (dom_force_lpo_o == '0));
endmodule

bind oscmon_top oscmon_chk #(.N_DOM(N_DOM)) u_chk (
    .ref_clk_i      (ref_clk_i),
    .rst_i          (rst_i),
    .ctl_reg_i      (ctl_reg_i),
    .ref_valid_i    (ref_valid_i),
    .fail_clr_i     (fail_clr_i),
    .dom_uses_osc_i (dom_uses_osc_i),
    .fail_o         (fail_o),
    .dom_force_lpo_o(dom_force_lpo_o)
);

// File: tb/oscmon_top_bench.sv
`timescale 1ns/1ps
module oscmon_top_bench;
    localparam int CNT_W  = 12;
    localparam int WIN    = 1024;
    localparam int N_DOM  = 4;
    localparam int LIM_LO = 10;
    localparam int LIM_HI = 200;
    localparam real REF_PERIOD = 5.0;

    logic             ref_clk;
    logic             rst;
    logic             osc_clk;
    logic [31:0]      ctl;
    logic             ref_valid;
    logic [CNT_W-1:0] lim_lo;
    logic [CNT_W-1:0] lim_hi;
    logic             fail_clr;
    logic [N_DOM-1:0] dom_uses;
    logic             fail;
    logic [N_DOM-1:0] dom_force;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    real osc_half = 10.0;
    bit  osc_run = 1;

    oscmon_top #(.CNT_W(CNT_W), .WIN_CYCLES(WIN), .N_DOM(N_DOM)) u_oscmon_top (
        .ref_clk_i      (ref_clk),
        .rst_i          (rst),
        .osc_clk_i      (osc_clk),
        .ctl_reg_i      (ctl),
        .ref_valid_i    (ref_valid),
        .lim_lo_i       (lim_lo),
        .lim_hi_i       (lim_hi),
        .fail_clr_i     (fail_clr),
        .dom_uses_osc_i (dom_uses),
        .fail_o         (fail),
        .dom_force_lpo_o(dom_force)
    );

    initial begin
        ref_clk = 1'b0;
        forever #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;
    end

    initial begin
        osc_clk = 1'b0;
        forever begin
            if (osc_run) begin
                #(osc_half);
                osc_clk = ~osc_clk;
            end else begin
                osc_clk = 1'b0;
                #(1.0);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    function automatic bit exp_fail(input bit sel, input bit en25, input bit rv,
                                    input bit stopped, input real period);
        bit  en;
        real cnt;
        en = !sel || en25;
        if (!en) return 1'b0;
        if (!rv) return 1'b1;
        if (stopped) return 1'b1;
        cnt = (WIN * REF_PERIOD) / period;
        return (cnt < LIM_LO) || (cnt > LIM_HI);
    endfunction

    task automatic run_trial(input string tag, input bit sel, input bit en25, input bit rv,
                             input bit stopped, input real period, input logic [N_DOM-1:0] uses);
        bit e;
        ctl      = 32'h0;
        ctl[24]  = sel;
        ctl[25]  = en25;
        ref_valid = rv;
        dom_uses = uses;
        osc_run  = !stopped;
        osc_half = period / 2.0;
        cycles(3 * WIN);
        fail_clr = 1'b1;
        cycles(1);
        fail_clr = 1'b0;
        cycles(2 * WIN + 200);
        e = exp_fail(sel, en25, rv, stopped, period);
        chk({tag, " fail_o"}, {31'b0, fail}, {31'b0, e});
        chk("R9 dom_force_lpo_o", {28'b0, dom_force}, {28'b0, uses & {N_DOM{e}}});
    endtask

    initial begin
        rst = 1'b1; ctl = 32'h0; ref_valid = 1'b1; fail_clr = 1'b0;
        lim_lo = CNT_W'(LIM_LO); lim_hi = CNT_W'(LIM_HI); dom_uses = 4'b1011;
        void'($urandom(32'd7341));
        cycles(20);
        chk("R10 fail_o after reset", {31'b0, fail}, 32'h0);
        chk("R10 dom_force_lpo_o after reset", {28'b0, dom_force}, 32'h0);
        rst = 1'b0;

        run_trial("R4 in range", 0, 0, 1, 0, 50.0, 4'b1111);
        // R8: clear took effect with good clock, now drop reference -> R6
        ref_valid = 1'b0;
        cycles(2);
        chk("R6 fail_o after ref_valid drop", {31'b0, fail}, 32'h1);
        ref_valid = 1'b1;
        cycles(WIN);
        chk("R8 fail_o sticky without clear", {31'b0, fail}, 32'h1);
        fail_clr = 1'b1; cycles(1); fail_clr = 1'b0;
        cycles(2);
        chk("R8 fail_o cleared", {31'b0, fail}, 32'h0);

        run_trial("R2 too slow", 0, 0, 1, 0, 1000.0, 4'b0101);
        run_trial("R3 too fast", 0, 0, 1, 0, 10.0, 4'b1110);
        run_trial("R5 stopped", 0, 0, 1, 1, 50.0, 4'b1111);
        run_trial("R1 sel=0 en25=0 still on", 0, 0, 1, 0, 8.0, 4'b0011);
        run_trial("R1 sel=1 en25=1 on", 1, 1, 1, 0, 8.0, 4'b1100);
        run_trial("R7 off ignores ref_valid", 1, 0, 0, 0, 50.0, 4'b1111);
        run_trial("R7 off ignores stopped osc", 1, 0, 1, 1, 50.0, 4'b1111);
        run_trial("R6 ref invalid while on", 1, 1, 0, 0, 50.0, 4'b1001);

        for (int t = 0; t < 11; t++) begin
            bit  sel, en25, rv;
            real per, cnt;
            sel  = $urandom_range(0, 1);
            en25 = $urandom_range(0, 1);
            rv   = ($urandom_range(0, 7) != 0);
            forever begin
                per = real'($urandom_range(8, 1200));
                cnt = (WIN * REF_PERIOD) / per;
                if ((cnt < LIM_LO - 2 || cnt > LIM_LO + 2) &&
                    (cnt < LIM_HI - 2 || cnt > LIM_HI + 2)) break;
            end
            run_trial("R2/R3/R4 random", sel, en25, rv, 0, per, N_DOM'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 195000; i++) begin
            @(posedge ref_clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule